// File: doc/BRIEF.md
# Descriptor-Driven Transfer Engine

This block moves data between two places in memory without the CPU touching each unit. A peripheral raises its request line, or software pulses a start input with a source index. The engine reads that source's entry in a vector table to find a transfer descriptor. It fetches the descriptor, performs the transfers it describes and writes the updated addresses and counts back. It then tells the requester what happened. Either the request flag is cleared because more transfers remain, or the count has run out: the source's enable bit is dropped and an interrupt goes to the CPU.

All memory traffic uses one synchronous master port. Read data returns on the cycle after the request. Descriptors can be chained, so one activation can walk several descriptors stored back to back. Each descriptor runs in normal mode, one unit per activation, or in block mode, one whole block per activation.

Top module: `xfer_engine`

## Requirements
- R1: An activation of source i reads the 16-bit word at VEC_BASE + 2*i. That word is the byte address of the source's first descriptor. Memory is only accessed while `busy` is high.
- R2: A descriptor is six little-endian 16-bit words at byte offsets 0, 2, 4, 6, 8 and 10: control, link, source address, destination address, count A, count B. Control bits [1:0] are the source address mode, [3:2] the destination address mode, [5:4] the transfer mode and [6] the unit size. Link bit 0 is the chain bit.
- R3: Address mode 00 keeps the address fixed. Mode 10 adds the unit size in bytes after each unit.
- R4: Size 0 moves one byte on data bits [7:0]. Size 1 moves a 16-bit word, low byte at the even address. Word accesses always use even addresses.
- R5: Transfer mode 00 (normal) moves one unit per activation and decrements count A by one. The count has ended when count A becomes 0.
- R6: Transfer mode 10 (block) moves one whole block per activation. Count A[7:0] counts down the units of the block. When it reaches 0 it is reloaded from count A[15:8], and count B is decremented. The count has ended when count B becomes 0.
- R7: After a descriptor's transfers, the engine writes the updated source address, destination address, count A and count B back to offsets 4, 6, 8 and 10.
- R8: When the chain bit is set, the descriptor 12 bytes further on runs next within the same activation.
- R9: A hardware activation in which no descriptor ended its count pulses `flag_clr` for the requesting source for one cycle. It leaves the enable bit set and raises no interrupt.
- R10: A hardware activation in which any descriptor ended its count clears the source's enable bit and pulses `cpu_irq` for that source for one cycle. It does not pulse `flag_clr`.
- R11: Enable bits are 0 after reset and are set by `en_set`. A request from a disabled source is ignored. When several enabled sources are pending, the lowest index is served first.
- R12: `sw_req` sampled while idle starts an activation for source `sw_sel`, whatever its enable bit. Such an activation changes no enable bit and pulses neither `flag_clr` nor `cpu_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_req | input | N_SRC | Peripheral request flags |
| en_set | input | N_SRC | Sets the matching enable bits |
| sw_req | input | 1 | Software start, sampled while idle |
| sw_sel | input | $clog2(N_SRC) | Source index for a software start |
| flag_clr | output | N_SRC | One-cycle pulse clearing a source's request flag |
| cpu_irq | output | N_SRC | One-cycle interrupt pulse for a source whose count ended |
| src_en | output | N_SRC | Current enable bits |
| busy | output | 1 | An activation is in progress |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_size | output | 1 | 0 byte, 1 word |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |

## Verification
The hardest situation to reach is the end of a count inside a chain or a block. Several activations must first walk the counts down, and the block reload has to fall on the same unit as the last block. The bench builds random descriptors with small counts and re-activates the same source until its reference model predicts the end. Every intermediate activation therefore exercises the flag-clear path, and the last one exercises the enable-drop and interrupt path. Directed cases add a two-descriptor chain, simultaneous requests from two sources and a software start of a disabled source.

// File: rtl/xe_pkg.sv
package xe_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_VRD, S_VCAP, S_DRD, S_DCAP, S_XRD, S_XCAP, S_WB, S_FIN
    } state_e;

    localparam logic [1:0] AM_INC   = 2'b10;
    localparam logic [1:0] XM_BLOCK = 2'b10;
    localparam int DSC_WORDS = 6;
    localparam int DSC_BYTES = 2 * DSC_WORDS;
    localparam int WB_OFFSET = 4;
endpackage

// File: rtl/xe_arb.sv
module xe_arb #(
    parameter int N  = 4,
    parameter int SW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    output logic          hit,
    output logic [SW-1:0] sel
);
    always_comb begin
        hit = |pend;
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) sel = SW'(i);
        end
    end
endmodule

// File: rtl/xe_step.sv
module xe_step
    import xe_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    mode,
    input  logic          wide,
    output logic [AW-1:0] nxt
);
    always_comb begin
        if (mode == AM_INC) nxt = addr + (wide ? AW'(2) : AW'(1));
        else                nxt = addr;
    end
endmodule

// File: rtl/xe_count.sv
module xe_count #(
    parameter int CW = 16,
    localparam int HW = CW / 2
) (
    input  logic          blk,
    input  logic [CW-1:0] cra,
    input  logic [CW-1:0] crb,
    output logic [CW-1:0] cra_nx,
    output logic [CW-1:0] crb_nx,
    output logic          grp_done,
    output logic          cnt_end
);
    logic [HW-1:0] lo_nx;

    always_comb begin
        lo_nx    = cra[HW-1:0] - HW'(1);
        cra_nx   = cra;
        crb_nx   = crb;
        grp_done = 1'b0;
        cnt_end  = 1'b0;
        if (blk) begin
            if (lo_nx == '0) begin
                cra_nx   = {cra[CW-1:HW], cra[CW-1:HW]};
                crb_nx   = crb - CW'(1);
                grp_done = 1'b1;
                cnt_end  = (crb == CW'(1));
            end else begin
                cra_nx = {cra[CW-1:HW], lo_nx};
            end
        end else begin
            cra_nx   = cra - CW'(1);
            grp_done = 1'b1;
            cnt_end  = (cra == CW'(1));
        end
    end
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
    import xe_pkg::*;
#(
    parameter int            N_SRC    = 4,
    parameter int            AW       = 16,
    parameter logic [AW-1:0] VEC_BASE = AW'('h40)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_SRC-1:0]         act_req,
    input  logic [N_SRC-1:0]         en_set,
    input  logic                     sw_req,
    input  logic [$clog2(N_SRC)-1:0] sw_sel,
    output logic [N_SRC-1:0]         flag_clr,
    output logic [N_SRC-1:0]         cpu_irq,
    output logic [N_SRC-1:0]         src_en,
    output logic                     busy,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic                     mem_size,
    output logic [AW-1:0]            mem_addr,
    output logic [15:0]              mem_wdata,
    input  logic [15:0]              mem_rdata
);
    localparam int SEL_W = $clog2(N_SRC);
    localparam int CW    = 16;

    typedef struct packed {
        state_e             st;
        logic [SEL_W-1:0]   sel;
        logic               hw;
        logic               eoc;
        logic [2:0]         idx;
        logic [AW-1:0]      dsc;
        logic [1:0]         smode;
        logic [1:0]         dmode;
        logic [1:0]         xmode;
        logic               wide;
        logic               chain;
        logic [AW-1:0]      sar;
        logic [AW-1:0]      dar;
        logic [CW-1:0]      cra;
        logic [CW-1:0]      crb;
        logic [N_SRC-1:0]   en;
    } regs_t;

    localparam regs_t RST = '{st: S_IDLE, default: '0};

    regs_t q, d;

    logic [N_SRC-1:0] pend_w;
    logic             arb_hit;
    logic [SEL_W-1:0] arb_sel;
    logic [AW-1:0]    sar_nx, dar_nx;
    logic [CW-1:0]    cra_nx, crb_nx;
    logic             grp_done, cnt_end;
    logic [N_SRC-1:0] sel_oh;

    assign pend_w = act_req & q.en;
    assign sel_oh = N_SRC'(1) << q.sel;

    xe_arb #(.N(N_SRC)) u_arb (
        .pend (pend_w),
        .hit  (arb_hit),
        .sel  (arb_sel)
    );

    xe_step #(.AW(AW)) u_sstep (
        .addr (q.sar),
        .mode (q.smode),
        .wide (q.wide),
        .nxt  (sar_nx)
    );

    xe_step #(.AW(AW)) u_dstep (
        .addr (q.dar),
        .mode (q.dmode),
        .wide (q.wide),
        .nxt  (dar_nx)
    );

    xe_count #(.CW(CW)) u_cnt (
        .blk      (q.xmode == XM_BLOCK),
        .cra      (q.cra),
        .crb      (q.crb),
        .cra_nx   (cra_nx),
        .crb_nx   (crb_nx),
        .grp_done (grp_done),
        .cnt_end  (cnt_end)
    );

    always_comb begin
        d         = q;
        d.en      = q.en | en_set;
        flag_clr  = '0;
        cpu_irq   = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_size  = 1'b1;
        mem_addr  = '0;
        mem_wdata = '0;
        case (q.st)
            S_IDLE: begin
                if (arb_hit) begin
                    d.sel = arb_sel;
                    d.hw  = 1'b1;
                    d.eoc = 1'b0;
                    d.st  = S_VRD;
                end else if (sw_req) begin
                    d.sel = sw_sel;
                    d.hw  = 1'b0;
                    d.eoc = 1'b0;
                    d.st  = S_VRD;
                end
            end
            S_VRD: begin
                mem_req  = 1'b1;
                mem_addr = VEC_BASE + AW'({q.sel, 1'b0});
                d.st     = S_VCAP;
            end
            S_VCAP: begin
                d.dsc = AW'(mem_rdata);
                d.idx = '0;
                d.st  = S_DRD;
            end
            S_DRD: begin
                mem_req  = 1'b1;
                mem_addr = q.dsc + AW'({q.idx, 1'b0});
                d.st     = S_DCAP;
            end
            S_DCAP: begin
                case (q.idx)
                    3'd0: begin
                        d.smode = mem_rdata[1:0];
                        d.dmode = mem_rdata[3:2];
                        d.xmode = mem_rdata[5:4];
                        d.wide  = mem_rdata[6];
                    end
                    3'd1:    d.chain = mem_rdata[0];
                    3'd2:    d.sar   = AW'(mem_rdata);
                    3'd3:    d.dar   = AW'(mem_rdata);
                    3'd4:    d.cra   = mem_rdata;
                    default: d.crb   = mem_rdata;
                endcase
                if (q.idx == 3'(DSC_WORDS - 1)) begin
                    d.st = S_XRD;
                end else begin
                    d.idx = q.idx + 3'd1;
                    d.st  = S_DRD;
                end
            end
            S_XRD: begin
                mem_req  = 1'b1;
                mem_size = q.wide;
                mem_addr = q.sar;
                d.st     = S_XCAP;
            end
            S_XCAP: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_size  = q.wide;
                mem_addr  = q.dar;
                mem_wdata = q.wide ? mem_rdata : {8'h00, mem_rdata[7:0]};
                d.sar     = sar_nx;
                d.dar     = dar_nx;
                d.cra     = cra_nx;
                d.crb     = crb_nx;
                d.eoc     = q.eoc | cnt_end;
                if (grp_done) begin
                    d.idx = '0;
                    d.st  = S_WB;
                end else begin
                    d.st  = S_XRD;
                end
            end
            S_WB: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = q.dsc + AW'(WB_OFFSET) + AW'({q.idx, 1'b0});
                case (q.idx)
                    3'd0:    mem_wdata = 16'(q.sar);
                    3'd1:    mem_wdata = 16'(q.dar);
                    3'd2:    mem_wdata = q.cra;
                    default: mem_wdata = q.crb;
                endcase
                if (q.idx == 3'd3) begin
                    if (q.chain) begin
                        d.dsc = q.dsc + AW'(DSC_BYTES);
                        d.idx = '0;
                        d.st  = S_DRD;
                    end else begin
                        d.st  = S_FIN;
                    end
                end else begin
                    d.idx = q.idx + 3'd1;
                end
            end
            S_FIN: begin
                if (q.hw) begin
                    if (q.eoc) begin
                        cpu_irq = sel_oh;
                        d.en    = d.en & ~sel_oh;
                    end else begin
                        flag_clr = sel_oh;
                    end
                end
                d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign busy   = (q.st != S_IDLE);
    assign src_en = q.en;
endmodule

// File: rtl/xe_chk.sv
module xe_chk #(
    parameter int N_SRC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] act_req,
    input logic             sw_req,
    input logic [N_SRC-1:0] flag_clr,
    input logic [N_SRC-1:0] cpu_irq,
    input logic [N_SRC-1:0] src_en,
    input logic             busy,
    input logic             mem_req,
    input logic             mem_size,
    input logic             addr_lsb
);
    AST_CLR_ONEHOT:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(flag_clr)); // R9
    AST_IRQ_ONEHOT:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cpu_irq)); // R10
    AST_CLR_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n) (flag_clr & cpu_irq) == '0); // R10
    AST_IRQ_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n) (|cpu_irq) |=> ((src_en & $past(cpu_irq)) == '0)); // R10
    AST_CLR_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n) (|flag_clr) |=> ((src_en & $past(flag_clr)) == $past(flag_clr))); // R9
    AST_WORD_EVEN:    assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_size) |-> !addr_lsb); // R4
    AST_MEM_BUSY:     assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy); // R1
    AST_STAY_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) (!busy && ((act_req & src_en) == '0) && !sw_req) |=> !busy); // R11
endmodule

bind xfer_engine xe_chk #(.N_SRC(N_SRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_req  (act_req),
    .sw_req   (sw_req),
    .flag_clr (flag_clr),
    .cpu_irq  (cpu_irq),
    .src_en   (src_en),
    .busy     (busy),
    .mem_req  (mem_req),
    .mem_size (mem_size),
    .addr_lsb (mem_addr[0])
);

// File: tb/tb_xfer_engine.sv
module tb_xfer_engine;
    localparam int N   = 4;
    localparam int MW  = 4096;
    localparam int VEC = 'h40;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [N-1:0]  act_req = '0, en_set = '0;
    logic          sw_req = 1'b0;
    logic [1:0]    sw_sel = '0;
    logic [N-1:0]  flag_clr, cpu_irq, src_en;
    logic          busy, mem_req, mem_we, mem_size;
    logic [15:0]   mem_addr, mem_wdata, mem_rdata;

    xfer_engine dut (
        .clk(clk), .rst_n(rst_n), .act_req(act_req), .en_set(en_set),
        .sw_req(sw_req), .sw_sel(sw_sel), .flag_clr(flag_clr), .cpu_irq(cpu_irq),
        .src_en(src_en), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    logic [7:0] dmem [MW];
    logic [7:0] emem [MW];
    int vecs = 0, fails = 0, cycles = 0;

    always @(posedge clk) begin
        automatic int a = int'(mem_addr[11:0]);
        if (mem_req) begin
            if (mem_we) begin
                if (mem_size) begin
                    dmem[a]   <= mem_wdata[7:0];
                    dmem[(a + 1) % MW] <= mem_wdata[15:8];
                end else begin
                    dmem[a] <= mem_wdata[7:0];
                end
            end else begin
                mem_rdata <= mem_size ? {dmem[(a + 1) % MW], dmem[a]} : {8'h00, dmem[a]};
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    function automatic logic [15:0] er16(input int a);
        return {emem[(a + 1) % MW], emem[a % MW]};
    endfunction

    task automatic ew16(input int a, input logic [15:0] v);
        emem[a % MW] = v[7:0];
        emem[(a + 1) % MW] = v[15:8];
    endtask

    task automatic put16(input int a, input logic [15:0] v);
        ew16(a, v);
        dmem[a % MW] = v[7:0];
        dmem[(a + 1) % MW] = v[15:8];
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cmp_mem(input string req, input string what);
        int bad = -1;
        for (int i = 0; i < MW; i++) begin
            if (bad < 0 && dmem[i] !== emem[i]) bad = i;
        end
        if (bad < 0) chk(1'b1, req, what, 0, 0);
        else chk(1'b0, req, what, {bad[15:0], 8'h00, dmem[bad]}, {bad[15:0], 8'h00, emem[bad]});
    endtask

    function automatic logic [15:0] ctl(input bit w, input logic [1:0] xm,
                                        input logic [1:0] dm, input logic [1:0] sm);
        return {9'd0, w, xm, dm, sm};
    endfunction

    task automatic put_desc(input int at, input logic [15:0] c, input logic [15:0] lnk,
                            input logic [15:0] s, input logic [15:0] d,
                            input logic [15:0] ca, input logic [15:0] cb);
        put16(at, c); put16(at + 2, lnk); put16(at + 4, s);
        put16(at + 6, d); put16(at + 8, ca); put16(at + 10, cb);
    endtask

    // reference model of one activation, on the expected memory
    task automatic model_act(input int src, output bit eoc);
        int dsc;
        logic [15:0] c, lnk, s, d, ca, cb;
        bit done;
        eoc = 1'b0;
        dsc = int'(er16(VEC + 2 * src));
        forever begin
            c = er16(dsc); lnk = er16(dsc + 2); s = er16(dsc + 4);
            d = er16(dsc + 6); ca = er16(dsc + 8); cb = er16(dsc + 10);
            done = 1'b0;
            while (!done) begin
                if (c[6]) ew16(int'(d), er16(int'(s)));
                else emem[d[11:0]] = emem[s[11:0]];
                if (c[1:0] == 2'b10) s = s + (c[6] ? 16'd2 : 16'd1);
                if (c[3:2] == 2'b10) d = d + (c[6] ? 16'd2 : 16'd1);
                if (c[5:4] == 2'b10) begin
                    if (ca[7:0] == 8'd1) begin
                        ca = {ca[15:8], ca[15:8]};
                        cb = cb - 16'd1;
                        done = 1'b1;
                        if (cb == 16'd0) eoc = 1'b1;
                    end else begin
                        ca[7:0] = ca[7:0] - 8'd1;
                    end
                end else begin
                    ca = ca - 16'd1;
                    done = 1'b1;
                    if (ca == 16'd0) eoc = 1'b1;
                end
            end
            ew16(dsc + 4, s); ew16(dsc + 6, d); ew16(dsc + 8, ca); ew16(dsc + 10, cb);
            if (lnk[0]) dsc += 12;
            else break;
        end
    endtask

    task automatic pulse_en(input logic [N-1:0] m);
        @(negedge clk); en_set = m;
        @(negedge clk); en_set = '0;
    endtask

    // raise requests and act as the peripherals until every one is answered
    task automatic run(input logic [N-1:0] mask, output logic [N-1:0] first,
                       output logic [N-1:0] flags, output logic [N-1:0] irqs);
        bit seen = 1'b0;
        first = '0; flags = '0; irqs = '0;
        @(negedge clk); act_req = act_req | mask;
        for (int cyc = 0; cyc < 5000; cyc++) begin
            @(negedge clk);
            if (busy) seen = 1'b1;
            if ((flag_clr | cpu_irq) != '0) begin
                if (first == '0) first = flag_clr | cpu_irq;
                flags = flags | flag_clr;
                irqs = irqs | cpu_irq;
                act_req = act_req & ~(flag_clr | cpu_irq);
            end
            if (act_req == '0 && !busy && seen) break;
        end
    endtask

    task automatic run_sw(input logic [1:0] sel, output logic [N-1:0] flags,
                          output logic [N-1:0] irqs);
        flags = '0; irqs = '0;
        @(negedge clk); sw_sel = sel; sw_req = 1'b1;
        @(negedge clk); sw_req = 1'b0;
        for (int cyc = 0; cyc < 5000; cyc++) begin
            flags = flags | flag_clr;
            irqs = irqs | cpu_irq;
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [N-1:0] first, fl, iq;
        bit eoc, seen;
        void'($urandom(32'd4242));
        for (int i = 0; i < MW; i++) begin
            dmem[i] = 8'($urandom);
            emem[i] = dmem[i];
        end
        for (int s = 0; s < N; s++) put16(VEC + 2 * s, 16'(256 + 64 * s));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk(src_en == '0, "R11", "enables after reset", 32'(src_en), 0);
        chk(!busy && flag_clr == '0 && cpu_irq == '0, "R10", "idle outputs after reset",
            {busy, 3'd0, flag_clr, cpu_irq}, 0);

        // disabled source ignored
        put_desc(256 + 64, ctl(1'b0, 2'b00, 2'b10, 2'b10), 16'd0, 16'h0500, 16'h0900, 16'd5, 16'd0);
        @(negedge clk); act_req = 4'b0010;
        seen = 1'b0;
        repeat (30) begin
            @(negedge clk);
            if (busy) seen = 1'b1;
        end
        act_req = '0;
        chk(!seen, "R11", "disabled request started engine", 32'(seen), 0);
        cmp_mem("R11", "memory after disabled request");

        // priority between two enabled sources, neither ending
        pulse_en(4'b0110);
        put_desc(256 + 128, ctl(1'b1, 2'b00, 2'b10, 2'b10), 16'd0, 16'h0600, 16'h0a00, 16'd5, 16'd0);
        model_act(1, eoc);
        model_act(2, eoc);
        run(4'b0110, first, fl, iq);
        chk(first == 4'b0010, "R11", "lowest index served first", 32'(first), 32'b0010);
        chk(fl == 4'b0110 && iq == '0, "R9", "flag clears without interrupt", {fl, iq}, {4'b0110, 4'b0000});
        chk(src_en[2:1] == 2'b11, "R9", "enables kept", 32'(src_en), 32'b0110);
        cmp_mem("R5 R7", "normal mode single unit and write back");

        // software start of a disabled source whose count ends
        put_desc(256 + 192, ctl(1'b0, 2'b00, 2'b10, 2'b10), 16'd0, 16'h0700, 16'h0b00, 16'd1, 16'd0);
        model_act(3, eoc);
        run_sw(2'd3, fl, iq);
        chk(fl == '0 && iq == '0, "R12", "software start pulses", {fl, iq}, 0);
        chk(src_en[3] == 1'b0, "R12", "software start enable", 32'(src_en), 32'(src_en & 4'b0111));
        cmp_mem("R12", "software start memory");

        // block mode, word size, two blocks of three
        pulse_en(4'b0001);
        put_desc(256, ctl(1'b1, 2'b10, 2'b10, 2'b10), 16'd0, 16'h0400, 16'h0800, 16'h0303, 16'd2);
        model_act(0, eoc);
        run(4'b0001, first, fl, iq);
        chk(fl == 4'b0001 && iq == '0 && !eoc, "R6", "first block not ending", {fl, iq}, {4'b0001, 4'b0000});
        cmp_mem("R6 R7", "first block and reload");
        model_act(0, eoc);
        run(4'b0001, first, fl, iq);
        chk(iq == 4'b0001 && fl == '0 && eoc, "R10", "last block interrupts", {fl, iq}, {4'b0000, 4'b0001});
        chk(src_en[0] == 1'b0, "R10", "enable dropped at end", 32'(src_en), 32'(src_en & 4'b1110));
        cmp_mem("R6", "second block");

        // chain: byte normal then word block with a fixed destination
        put_desc(256 + 128, ctl(1'b0, 2'b00, 2'b10, 2'b10), 16'd1, 16'h0640, 16'h0a40, 16'd3, 16'd0);
        put_desc(256 + 140, ctl(1'b1, 2'b10, 2'b00, 2'b10), 16'd0, 16'h0660, 16'h0a60, 16'h0202, 16'd3);
        model_act(2, eoc);
        run(4'b0100, first, fl, iq);
        chk(fl == 4'b0100 && iq == '0, "R8", "chained activation flag", {fl, iq}, {4'b0100, 4'b0000});
        cmp_mem("R8 R3", "chained descriptors");

        // random descriptors, run each to the end of its count
        for (int t = 0; t < 60; t++) begin
            int src, base, acts;
            bit ch;
            logic [N-1:0] oh;
            src = int'($urandom_range(0, N - 1));
            oh = N'(1) << src;
            base = 256 + 64 * src;
            ch = 1'($urandom);
            for (int k = 0; k < 2; k++) begin
                bit w, blk;
                logic [15:0] ca, cb;
                w = 1'($urandom);
                blk = 1'($urandom);
                if (blk) begin
                    ca[7:0] = 8'($urandom_range(1, 4));
                    ca[15:8] = ca[7:0];
                    cb = 16'($urandom_range(1, 3));
                end else begin
                    ca = 16'($urandom_range(1, 4));
                    cb = 16'($urandom);
                end
                put_desc(base + 12 * k,
                         ctl(w, blk ? 2'b10 : 2'b00, $urandom_range(0, 1) ? 2'b10 : 2'b00,
                             $urandom_range(0, 1) ? 2'b10 : 2'b00),
                         (k == 0) ? 16'(ch) : 16'd0,
                         16'(1024 + 256 * src + 128 * k), 16'(2048 + 256 * src + 128 * k), ca, cb);
            end
            pulse_en(oh);
            eoc = 1'b0;
            acts = 0;
            while (!eoc && acts < 8) begin
                acts++;
                model_act(src, eoc);
                run(oh, first, fl, iq);
                if (eoc) chk(iq == oh && fl == '0, "R10", "end of count pulses", {fl, iq}, {4'b0000, oh});
                else chk(fl == oh && iq == '0, "R9", "mid count pulses", {fl, iq}, {oh, 4'b0000});
                cmp_mem("R1 R2 R3 R4 R7", "random descriptor memory");
            end
            chk((src_en & oh) == '0, "R10", "enable after end", 32'(src_en), 32'(src_en & ~oh));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule